// File: doc/BRIEF.md
# MSK Transmit Modulator with Bit Clock

This block turns a serial bit stream from a host into a sampled minimum-shift-keyed tone at 2400 bit/s. A fractional divider derives the bit timing from the master clock. The block drives a bit clock out to the host and captures the host's data bit at each rising edge of that clock. For each bit it produces a phase-continuous tone: half a sine cycle per bit for a data 1 (1.2 kHz) and one full cycle per bit for a data 0 (2.4 kHz). The output is an 8-bit signed sine code for an external DAC.

An active-low transmit control starts and stops the stream. While it is high, the bit clock is parked high. When it is released, the clock drops for one half period and then rises to open the first bit. When it is raised again, the bit in flight runs to completion and the tone then falls silent. A path select chooses between the tone and an 8-bit voice code at the output.

Top module: `msk_tx_mod`

## Requirements
- R1: During and directly after reset, `tx_clk` is 1 and the tone code is 0.
- R2: While the synchronised `tx_hold` is 1, `tx_clk` stays at 1. After a stream has stopped, `tx_clk` shows no further rising edge and the tone code stays 0.
- R3: `tx_hold` passes through a two-stage synchroniser. After `tx_hold` falls, `tx_clk` goes low at the third rising clock edge. It stays low for one half-bit period and then rises, which opens the first bit. The tone phase of that first bit starts at 0.
- R4: Each bit spans two half-bit periods, with `tx_clk` high in the first half and low in the second. A half-bit period averages 2^ACC_W / HALF_INC clock cycles. With the default parameters, 20 bit periods last 20·3579545/2400 cycles to within 3 cycles.
- R5: `tx_data` is captured in the cycle in which `tx_clk` rises. That value controls the whole bit that follows.
- R6: The phase is counted in units of 1/256 of a sine cycle. Within a bit, the phase equals the bit's base phase plus the progress P. P is 64 times the half-bit index plus the top six bits of the divider accumulator. For a data 1 the progress term is P; for a data 0 it is 2·P.
- R7: The base phase of each bit after the first equals the previous base plus 128 if the previous bit was 1, or plus 0 if it was 0. There is no phase jump at a bit boundary.
- R8: The tone code is an 8-bit two's-complement value. It equals round(127·sin(2π(φ+0.5)/256)) to within ±1, where φ is the phase one cycle earlier. It never takes the value −128.
- R9: If `tx_hold` rises during a bit, that bit completes. The tone code is 0 from the cycle after the bit's end.
- R10: If `tx_hold` rises before the first rising edge of `tx_clk`, no bit is opened. `tx_clk` returns to 1 and the tone code stays 0.
- R11: `tx_out` equals `voice_in` while `path_sel` is 0 and the tone code while `path_sel` is 1. The tone keeps advancing while the voice path is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_hold | input | 1 | Active-low transmit control (1 = hold, 0 = transmit), asynchronous |
| tx_data | input | 1 | Serial data bit from the host |
| path_sel | input | 1 | Output select: 1 = tone, 0 = voice |
| voice_in | input | 8 | Voice sample code passed through when selected |
| tx_clk | output | 1 | Bit clock to the host, parked high |
| tx_out | output | 8 | Signed sample code to the DAC |

## Verification
The hardest situations to reach are the edges of the transmit window. One is a hold that arrives during the lead-in half period, before any bit exists. The other is a hold that arrives mid-bit, where the clock must park at once but the tone must still finish the bit. The stimulus places the hold at known offsets from the observed clock edges, counting the two synchroniser stages, so that each case lands inside the intended half period. Phase continuity is covered by a 2048-bit stream of every byte value, sent back to back. In this stream the base phase must accumulate correctly across all transitions between ones and zeros, with the voice path selected for one bit in the middle.

// File: rtl/msk_tx_pkg.sv
package msk_tx_pkg;

    localparam int PHASE_W   = 8;
    localparam int CODE_W    = 8;
    localparam int FRAC_W    = 6;
    localparam int QTR_DEPTH = 1 << FRAC_W;
    localparam int MAG_W     = CODE_W - 1;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LEAD = 2'd1,
        ST_RUN  = 2'd2
    } clk_state_e;

    typedef struct packed {
        logic              bit_start;
        logic              first;
        logic              active;
        logic              half;
        logic [FRAC_W-1:0] frac;
    } bit_timing_t;

    // Accumulator step for one overflow per half-bit period, rounded.
    function automatic int unsigned calc_half_inc(input longint clk_hz,
                                                  input longint bit_hz,
                                                  input int     acc_w);
        longint num;
        num = (2 * bit_hz) << acc_w;
        return int'((num + clk_hz / 2) / clk_hz);
    endfunction

    // Quarter-wave magnitude at half-sample offsets, rational sine approximation.
    function automatic int quarter_sine(input int idx);
        int u, p, num, den;
        u   = 2 * idx + 1;
        p   = u * (256 - u);
        num = 16 * p;
        den = 5 * 65536 - 4 * p;
        return (127 * num + den / 2) / den;
    endfunction

endpackage

// File: rtl/msk_bitclk_gen.sv
module msk_bitclk_gen
    import msk_tx_pkg::*;
#(
    parameter int          ACC_W       = 24,
    parameter int unsigned HALF_INC    = 22497,
    parameter int          SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        tx_hold,
    output logic        tx_clk,
    output bit_timing_t timing
);

    localparam logic [ACC_W:0] STEP = (ACC_W+1)'(HALF_INC);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   hold_s;

    generate
        if (SYNC_STAGES == 1) begin : g_sync1
            always_ff @(posedge clk) begin
                if (rst) sync_q <= '1;
                else     sync_q <= tx_hold;
            end
        end else begin : g_syncn
            always_ff @(posedge clk) begin
                if (rst) sync_q <= '1;
                else     sync_q <= {sync_q[SYNC_STAGES-2:0], tx_hold};
            end
        end
    endgenerate

    assign hold_s = sync_q[SYNC_STAGES-1];

    clk_state_e       state_q, state_n;
    logic [ACC_W-1:0] acc_q, acc_n;
    logic             half_q, half_n;
    logic             tclk_q, tclk_n;
    logic             start_c, first_c;
    logic [ACC_W:0]   sum;
    logic             carry;

    assign sum   = {1'b0, acc_q} + STEP;
    assign carry = sum[ACC_W];

    always_comb begin
        state_n = state_q;
        acc_n   = acc_q;
        half_n  = half_q;
        tclk_n  = tclk_q;
        start_c = 1'b0;
        first_c = 1'b0;
        case (state_q)
            ST_IDLE: begin
                acc_n  = '0;
                half_n = 1'b0;
                tclk_n = 1'b1;
                if (!hold_s) begin
                    state_n = ST_LEAD;
                    tclk_n  = 1'b0;
                end
            end
            ST_LEAD: begin
                if (hold_s) begin
                    state_n = ST_IDLE;
                    acc_n   = '0;
                    tclk_n  = 1'b1;
                end else begin
                    acc_n = sum[ACC_W-1:0];
                    if (carry) begin
                        state_n = ST_RUN;
                        half_n  = 1'b0;
                        tclk_n  = 1'b1;
                        start_c = 1'b1;
                        first_c = 1'b1;
                    end
                end
            end
            ST_RUN: begin
                acc_n = sum[ACC_W-1:0];
                if (carry) begin
                    if (!half_q) begin
                        half_n = 1'b1;
                        tclk_n = hold_s;
                    end else if (hold_s) begin
                        state_n = ST_IDLE;
                        acc_n   = '0;
                        half_n  = 1'b0;
                        tclk_n  = 1'b1;
                    end else begin
                        half_n  = 1'b0;
                        tclk_n  = 1'b1;
                        start_c = 1'b1;
                    end
                end else if (hold_s) begin
                    tclk_n = 1'b1;
                end
            end
            default: begin
                state_n = ST_IDLE;
                acc_n   = '0;
                half_n  = 1'b0;
                tclk_n  = 1'b1;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            acc_q   <= '0;
            half_q  <= 1'b0;
            tclk_q  <= 1'b1;
        end else begin
            state_q <= state_n;
            acc_q   <= acc_n;
            half_q  <= half_n;
            tclk_q  <= tclk_n;
        end
    end

    assign tx_clk           = tclk_q;
    assign timing.bit_start = start_c;
    assign timing.first     = first_c;
    assign timing.active    = (state_q == ST_RUN);
    assign timing.half      = half_q;
    assign timing.frac      = acc_q[ACC_W-1 -: FRAC_W];

    assert_park_high_R2: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE) |-> tclk_q);

    assert_lead_low_R3: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_LEAD) |-> !tclk_q);

    assert_rise_opens_bit_R5: assert property (@(posedge clk) disable iff (rst)
        start_c |=> (tclk_q && state_q == ST_RUN && !half_q));

endmodule

// File: rtl/msk_phase_ctl.sv
module msk_phase_ctl
    import msk_tx_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  bit_timing_t        timing,
    input  logic               tx_data,
    output logic [PHASE_W-1:0] phase,
    output logic               phase_vld
);

    localparam logic [PHASE_W-1:0] HALF_TURN = PHASE_W'(1 << (PHASE_W - 1));

    logic [PHASE_W-1:0] base_q;
    logic               bit_q;
    logic [FRAC_W:0]    prog;

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q <= '0;
            bit_q  <= 1'b0;
        end else if (timing.bit_start) begin
            bit_q <= tx_data;
            if (timing.first) base_q <= '0;
            else              base_q <= base_q + (bit_q ? HALF_TURN : '0);
        end
    end

    assign prog      = {timing.half, timing.frac};
    assign phase     = base_q + (bit_q ? {1'b0, prog} : {prog, 1'b0});
    assign phase_vld = timing.active;

    assert_base_steady_R7: assert property (@(posedge clk) disable iff (rst)
        !timing.bit_start |=> $stable(base_q));

endmodule

// File: rtl/msk_sine_rom.sv
module msk_sine_rom
    import msk_tx_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [PHASE_W-1:0] phase,
    input  logic               phase_vld,
    output logic [CODE_W-1:0]  code
);

    logic [MAG_W-1:0]  qtab [QTR_DEPTH];
    logic [FRAC_W-1:0] idx;
    logic [MAG_W-1:0]  mag;
    logic [CODE_W-1:0] val;

    generate
        for (genvar i = 0; i < QTR_DEPTH; i++) begin : g_qtab
            assign qtab[i] = MAG_W'(quarter_sine(i));
        end
    endgenerate

    assign idx = phase[PHASE_W-2] ? ~phase[FRAC_W-1:0] : phase[FRAC_W-1:0];
    assign mag = qtab[idx];
    assign val = phase[PHASE_W-1] ? (CODE_W'(0) - {1'b0, mag}) : {1'b0, mag};

    always_ff @(posedge clk) begin
        if (rst)            code <= '0;
        else if (phase_vld) code <= val;
        else                code <= '0;
    end

    assert_silent_when_idle_R9: assert property (@(posedge clk) disable iff (rst)
        !phase_vld |=> (code == '0));

    assert_code_range_R8: assert property (@(posedge clk) disable iff (rst)
        code != {1'b1, {(CODE_W-1){1'b0}}});

endmodule

// File: rtl/msk_tx_mod.sv
module msk_tx_mod
    import msk_tx_pkg::*;
#(
    parameter longint      CLK_HZ   = 3579545,
    parameter longint      BIT_HZ   = 2400,
    parameter int          ACC_W    = 24,
    parameter int unsigned HALF_INC = calc_half_inc(CLK_HZ, BIT_HZ, ACC_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tx_hold,
    input  logic              tx_data,
    input  logic              path_sel,
    input  logic [CODE_W-1:0] voice_in,
    output logic              tx_clk,
    output logic [CODE_W-1:0] tx_out
);

    bit_timing_t        timing;
    logic [PHASE_W-1:0] phase;
    logic               phase_vld;
    logic [CODE_W-1:0]  tone;

    msk_bitclk_gen #(
        .ACC_W       (ACC_W),
        .HALF_INC    (HALF_INC),
        .SYNC_STAGES (2)
    ) u_bitclk (
        .clk     (clk),
        .rst     (rst),
        .tx_hold (tx_hold),
        .tx_clk  (tx_clk),
        .timing  (timing)
    );

    msk_phase_ctl u_phase (
        .clk       (clk),
        .rst       (rst),
        .timing    (timing),
        .tx_data   (tx_data),
        .phase     (phase),
        .phase_vld (phase_vld)
    );

    msk_sine_rom u_rom (
        .clk       (clk),
        .rst       (rst),
        .phase     (phase),
        .phase_vld (phase_vld),
        .code      (tone)
    );

    assign tx_out = path_sel ? tone : voice_in;

endmodule

// File: tb/msk_tx_mod_tb.sv
module msk_tx_mod_tb_top;

    logic       clk = 1'b0;
    logic       rst;
    logic       tx_hold, tx_data, path_sel;
    logic [7:0] voice_in;
    logic       tx_clk;
    logic [7:0] tx_out;

    logic       def_hold;
    logic       def_clk;
    logic [7:0] def_out;

    int  n_cmp = 0;
    int  n_bad = 0;
    bit  def_done = 1'b0;
    bit  finished = 1'b0;
    logic pat [0:2047];

    always #2 clk = ~clk;

    msk_tx_mod #(.ACC_W(8), .HALF_INC(64)) dut_i (
        .clk(clk), .rst(rst), .tx_hold(tx_hold), .tx_data(tx_data),
        .path_sel(path_sel), .voice_in(voice_in), .tx_clk(tx_clk), .tx_out(tx_out)
    );

    msk_tx_mod dut_def (
        .clk(clk), .rst(rst), .tx_hold(def_hold), .tx_data(1'b0),
        .path_sel(1'b1), .voice_in(8'h00), .tx_clk(def_clk), .tx_out(def_out)
    );

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic check_int(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int sine_ref(input int ph);
        real x;
        x = 127.0 * $sin(2.0 * 3.14159265358979 * (real'(ph) + 0.5) / 256.0);
        return int'($floor(x + 0.5));
    endfunction

    task automatic check_tone(input string req, input int ph);
        int act, exp, d;
        act = int'($signed(tx_out));
        exp = sine_ref(ph & 255);
        d   = act - exp;
        n_cmp++;
        if (d > 1 || d < -1) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d (phase %0d) at %0t",
                     req, act, exp, ph & 255, $time);
        end
    endtask

    // Sends pat[0..nbits-1]; hold is raised in the last bit; voice path in bit vbit.
    task automatic run_frame(input int nbits, input int vbit);
        int base;
        tx_data = pat[0];
        tx_hold = 1'b0;
        for (int c = 1; c <= 7; c++) begin
            step();
            check_int("R3 lead-in clock", int'(tx_clk), (c < 3 || c == 7) ? 1 : 0);
            check_int("R3 silent lead-in", int'(tx_out), 0);
        end
        base = 0;
        for (int j = 0; j < nbits; j++) begin
            int st;
            st = pat[j] ? 1 : 2;
            for (int k = 1; k <= 8; k++) begin
                step();
                if (j == nbits - 1)
                    check_int("R2 parked during final bit", int'(tx_clk), 1);
                else
                    check_int("R4 clock shape", int'(tx_clk), (k >= 4 && k <= 7) ? 0 : 1);
                check_tone("R6 R7 R8 tone", base + st * 16 * (k - 1));
                if (j == vbit) begin
                    path_sel = 1'b0;
                    voice_in = 8'(j * 37 + k);
                    #1;
                    check_int("R11 voice mid-stream", int'(tx_out), (j * 37 + k) & 255);
                    path_sel = 1'b1;
                    #1;
                end
                if (j == nbits - 1 && k == 1) tx_hold = 1'b1;
                if (k == 4 && j + 1 < nbits) tx_data = pat[j + 1]; // R5 set up on fall
            end
            base = (base + (pat[j] ? 128 : 0)) & 255;
        end
        for (int c = 1; c <= 12; c++) begin
            step();
            check_int("R9 silent after final bit", int'(tx_out), 0);
            check_int("R2 no rise after stop", int'(tx_clk), 1);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    // Default-parameter rate check (R4).
    initial begin
        int rises, first_cyc, cyc;
        logic prev;
        def_hold = 1'b1;
        @(negedge rst);
        step();
        def_hold = 1'b0;
        rises = 0; first_cyc = 0; cyc = 0; prev = 1'b1;
        while (rises < 21) begin
            step();
            cyc++;
            if (def_clk && !prev) begin
                rises++;
                if (rises == 1) first_cyc = cyc;
            end
            prev = def_clk;
        end
        n_cmp++;
        if ((cyc - first_cyc) < 29827 || (cyc - first_cyc) > 29833) begin
            n_bad++;
            $display("FAIL R4 default rate: actual %0d expected 29830 +-3", cyc - first_cyc);
        end
        def_hold = 1'b1;
        def_done = 1'b1;
    end

    initial begin
        rst = 1'b1; tx_hold = 1'b1; tx_data = 1'b0; path_sel = 1'b1; voice_in = 8'h00;
        repeat (3) step();
        check_int("R1 reset clock", int'(tx_clk), 1);
        check_int("R1 reset code", int'(tx_out), 0);
        rst = 1'b0;
        step();
        check_int("R1 clock after reset", int'(tx_clk), 1);
        check_int("R1 code after reset", int'(tx_out), 0);

        // R11: exhaustive voice pass-through while idle
        path_sel = 1'b0;
        for (int v = 0; v < 256; v++) begin
            voice_in = 8'(v);
            #1;
            check_int("R11 voice select", int'(tx_out), v);
        end
        path_sel = 1'b1;
        #1;
        check_int("R11 tone select idle", int'(tx_out), 0);

        // R2: held high for a while
        for (int c = 0; c < 10; c++) begin
            step();
            check_int("R2 parked while held", int'(tx_clk), 1);
        end

        // R10: hold returns during the lead-in half period
        tx_hold = 1'b0;
        for (int c = 1; c <= 3; c++) step();
        check_int("R10 clock low in lead-in", int'(tx_clk), 0);
        tx_hold = 1'b1;
        for (int c = 1; c <= 14; c++) begin
            step();
            if (c >= 3) check_int("R10 no bit opened", int'(tx_clk), 1);
            check_int("R10 silent", int'(tx_out), 0);
        end

        // Short frames: all ones, all zeros, alternating, single bits
        for (int i = 0; i < 6; i++) pat[i] = 1'b1;
        run_frame(6, -1);
        for (int i = 0; i < 6; i++) pat[i] = 1'b0;
        run_frame(6, -1);
        for (int i = 0; i < 9; i++) pat[i] = logic'(i % 2);
        run_frame(9, -1);
        pat[0] = 1'b1;
        run_frame(1, -1);
        pat[0] = 1'b0;
        run_frame(1, -1);

        // Every byte value, MSB first, one continuous stream
        for (int b = 0; b < 256; b++)
            for (int i = 0; i < 8; i++)
                pat[b * 8 + i] = logic'((b >> (7 - i)) & 1);
        run_frame(2048, 100);

        while (!def_done) step();
        finish_run();
    end

endmodule